// File: doc/BRIEF.md
# Remote DMA Data Port Engine

This block moves bytes between a host and an on-chip packet RAM through one data port. The register file hands it a remote start address, a byte count, the ring bounds and a word-mode configuration bit. Each host access through the port reads or writes 8, 16 or 32 bits at the current address. After each access the engine steps the address, wraps it from the ring stop back to the ring start, and counts down the remaining bytes. When the count runs out it raises a one-cycle remote-DMA-complete pulse, which the interrupt logic latches.

The engine also owns a 32-byte address PROM at the bottom of the address space. The PROM is loaded from the station MAC address after reset, and again whenever the host reads a separate reset port. A receive writer shares the packet RAM. It gets a write slot in every cycle in which the host is not using the data port, and it is told to stall in any cycle in which the host is using it.

Top module: `rdma_port_engine`

## Requirements
- R1: With `port_dword` low, `cfg_word16` high selects a 16-bit little-endian access that steps by 2. In that access the byte at the lower address sits in bits 7:0 and bits 31:16 read as zero. `cfg_word16` low selects an 8-bit access in bits 7:0 that steps by 1, with bits 31:8 zero. `port_dword` high selects a 32-bit little-endian access that steps by 4. `port_rdata` updates on the clock edge that takes a read strobe and holds until the next read.
- R2: After each access the address advances by the step. If the result equals `ring_stop`, the address reloads to `ring_start`.
- R3: After each access, a count less than or equal to the step becomes 0 and `dma_done` is high for the one cycle after that edge. Otherwise the step is subtracted from the count. Out of reset, the address, the count and `dma_done` are all 0.
- R4: A data-port write while the count is 0 changes nothing: not the memory, the address, the count or `dma_done`. A read at count 0 still performs the access, advances the address and pulses `dma_done`.
- R5: A command strobe with `cmd_rrd` or `cmd_rwr` set and `cmd_stop` clear, given while the count is 0, pulses `dma_done` in the next cycle. The same strobe given with `cmd_stop` set, or with a non-zero count, does not.
- R6: An access is allowed only if all of its bytes lie below address 32 or all lie in [`WIN_BASE`, `WIN_BASE+WIN_SIZE`). A read that is not allowed returns all ones across the access width, and a write that is not allowed is dropped.
- R7: For 16-bit and 32-bit accesses, address bit 0 is ignored when the memory is addressed. The stored address still steps from its unmasked value.
- R8: After reset, PROM source byte i is MAC byte i (bits 8i+7:8i of `mac_addr`) for i from 0 to 5, 0x57 for i of 14 and 15, and 0 otherwise. Each source byte i is stored at both PROM addresses 2i and 2i+1.
- R9: A read of the reset port (`port_sel` high) returns 0, reloads the PROM as in R8 and pulses `reset_done` one cycle after the edge. A write to the reset port has no effect. `reset_done` also pulses once after reset is released.
- R10: A receive write to a window address stores its byte when no data-port access occurs in the same cycle. When a data-port access does occur in that cycle, `rx_stall` is high and the byte is not stored.
- R11: `ld_addr` and `ld_cnt` load the address and the count on the next edge, and they take priority over the update made by an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mac_addr | input | 48 | Station address, byte i in bits 8i+7:8i |
| cfg_word16 | input | 1 | Word-mode configuration bit for accesses of 16 bits or less |
| ring_start | input | AW | Ring start byte address |
| ring_stop | input | AW | Ring stop byte address (one past the end) |
| ld_addr | input | 1 | Load strobe for the remote address |
| ld_addr_val | input | AW | Value for the remote address |
| ld_cnt | input | 1 | Load strobe for the byte count |
| ld_cnt_val | input | CW | Value for the byte count |
| cmd_wr | input | 1 | Command write strobe |
| cmd_stop | input | 1 | Stop bit of the command |
| cmd_rrd | input | 1 | Remote-read bit of the command |
| cmd_rwr | input | 1 | Remote-write bit of the command |
| port_rd | input | 1 | Host read strobe |
| port_wr | input | 1 | Host write strobe |
| port_sel | input | 1 | 0 selects the data port, 1 selects the reset port |
| port_dword | input | 1 | 32-bit access size |
| port_wdata | input | 32 | Host write data |
| port_rdata | output | 32 | Registered host read data |
| dma_addr | output | AW | Current remote address |
| dma_cnt | output | CW | Remaining byte count |
| dma_done | output | 1 | Remote-DMA-complete pulse |
| reset_done | output | 1 | Reset-complete pulse |
| rx_we | input | 1 | Receive writer byte strobe |
| rx_addr | input | AW | Receive writer byte address |
| rx_data | input | 8 | Receive writer byte |
| rx_stall | output | 1 | Receive write refused this cycle |

## Verification
A wrong address or count register shows at the ports by the next edge. `dma_addr` and `dma_cnt` expose both, and the data read back in the next access comes from the wrong place. A corrupted byte in the PROM or the window, or a dropped byte lane, only shows when that byte is next read through the port. The bench therefore reads back every PROM byte and every window byte after it writes them. A misplaced done pulse or a missed wrap is visible on the cycle after the access that caused it.

// File: rtl/rdma_pkg.sv
package rdma_pkg;

  localparam int unsigned PROM_BYTES = 32;

  typedef enum logic [1:0] {
    ACC_B8  = 2'd0,
    ACC_B16 = 2'd1,
    ACC_B32 = 2'd2
  } acc_width_e;

  function automatic logic [2:0] width_bytes(input acc_width_e w);
    case (w)
      ACC_B16: return 3'd2;
      ACC_B32: return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  // Source byte i of the reset image; stored twice in the PROM.
  function automatic logic [7:0] prom_src(input logic [47:0] mac, input logic [3:0] i);
    logic [47:0] sh;
    sh = mac >> {i[2:0], 3'b000};
    if (i < 4'd6)                    return sh[7:0];
    else if (i == 4'd14 || i == 4'd15) return 8'h57;
    else                             return 8'h00;
  endfunction

endpackage

// File: rtl/rdma_addr_ctl.sv
module rdma_addr_ctl #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic          cmd_wr,
  input  logic          cmd_stop,
  input  logic          cmd_rrd,
  input  logic          cmd_rwr,
  input  logic          rd_acc,
  input  logic          wr_acc,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic          wr_ok,
  output logic          done_q
);

  logic [AW-1:0] step_a, addr_sum, addr_nxt;
  logic [CW-1:0] step_c, cnt_nxt;
  logic          step_en, cnt_zero, exhaust, zero_cmd, done_nxt;
  logic          addr_en, cnt_en;

  assign step_a   = AW'(step);
  assign step_c   = CW'(step);
  assign cnt_zero = (cnt_q == '0);
  assign wr_ok    = wr_acc & ~cnt_zero;
  assign step_en  = rd_acc | wr_ok;
  assign addr_sum = addr_q + step_a;
  assign exhaust  = step_en & (cnt_q <= step_c);
  assign zero_cmd = cmd_wr & ~cmd_stop & (cmd_rrd | cmd_rwr) & cnt_zero;
  assign addr_en  = ld_addr | step_en;
  assign cnt_en   = ld_cnt | step_en;

  always_comb begin
    if (ld_addr)                  addr_nxt = ld_addr_val;
    else if (addr_sum == ring_stop) addr_nxt = ring_start;
    else                          addr_nxt = addr_sum;

    if (ld_cnt)       cnt_nxt = ld_cnt_val;
    else if (exhaust) cnt_nxt = '0;
    else              cnt_nxt = cnt_q - step_c;

    done_nxt = exhaust | zero_cmd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_nxt;
      if (cnt_en)  cnt_q  <= cnt_nxt;
      done_q <= done_nxt;
    end
  end

  // R3
  cnt_done_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && $past(step_en) && !$past(ld_cnt)) |-> (cnt_q == '0));

  // R3
  cnt_nonincr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_cnt |=> (cnt_q <= $past(cnt_q)));

  // R2
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_addr && (ring_start != ring_stop)) |=> (addr_q != $past(ring_stop)));

  // R4
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && !rd_acc && cnt_zero && !ld_addr && !ld_cnt) |=> ((addr_q == $past(addr_q)) && (cnt_q == '0)));

endmodule

// File: rtl/rdma_pkt_mem.sv
module rdma_pkt_mem
  import rdma_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned WIN_BASE = 64,
  parameter int unsigned WIN_SIZE = 64
) (
  input  logic          clk,
  input  logic          prom_load,
  input  logic [47:0]   mac,
  input  logic [AW-1:0] acc_addr,
  input  acc_width_e    acc_w,
  input  logic          we,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  input  logic          rx_we,
  input  logic [AW-1:0] rx_addr,
  input  logic [7:0]    rx_data
);

  localparam int unsigned TOT = PROM_BYTES + WIN_SIZE;
  localparam int unsigned IW  = $clog2(TOT);
  localparam int unsigned EW  = AW + 1;
  localparam logic [EW-1:0] PROM_END = EW'(PROM_BYTES);
  localparam logic [EW-1:0] WIN_LO   = EW'(WIN_BASE);
  localparam logic [EW-1:0] WIN_HI   = EW'(WIN_BASE + WIN_SIZE);

  logic [7:0]    mem_q [TOT];
  logic [2:0]    nb;
  logic [AW-1:0] base;
  logic [EW-1:0] last;
  logic          acc_ok;
  logic [IW-1:0] lane_idx [4];
  logic [3:0]    lane_we;
  logic          rx_in;
  logic [IW-1:0] rx_idx;
  logic [EW-1:0] rx_e;

  assign nb     = width_bytes(acc_w);
  assign base   = (acc_w == ACC_B8) ? acc_addr : {acc_addr[AW-1:1], 1'b0};
  assign last   = EW'(base) + EW'(nb) - EW'(1);
  assign acc_ok = (last < PROM_END) | ((EW'(base) >= WIN_LO) & (last < WIN_HI));

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [EW-1:0] lane_addr;
    logic          lane_on;
    assign lane_addr = EW'(base) + EW'(k);
    assign lane_on   = (3'(k) < nb);
    assign lane_idx[k] = !acc_ok ? '0 :
                         (lane_addr < PROM_END) ? IW'(lane_addr) :
                         IW'(lane_addr - WIN_LO + PROM_END);
    assign lane_we[k] = we & acc_ok & lane_on;
    assign rdata[8*k +: 8] = !lane_on ? 8'h00 :
                             acc_ok   ? mem_q[lane_idx[k]] : 8'hFF;
  end

  assign rx_e   = EW'(rx_addr);
  assign rx_in  = (rx_e >= WIN_LO) & (rx_e < WIN_HI);
  assign rx_idx = rx_in ? IW'(rx_e - WIN_LO + PROM_END) : '0;

  // Storage array: no reset, as for a RAM macro.
  always_ff @(posedge clk) begin
    if (prom_load) begin
      for (int j = 0; j < PROM_BYTES; j++)
        mem_q[j] <= prom_src(mac, 4'(j / 2));
    end else begin
      for (int k = 0; k < 4; k++)
        if (lane_we[k]) mem_q[lane_idx[k]] <= wdata[8*k +: 8];
    end
    if (rx_we && rx_in) mem_q[rx_idx] <= rx_data;
  end

endmodule

// File: rtl/rdma_port_engine.sv
module rdma_port_engine
  import rdma_pkg::*;
#(
  parameter int unsigned AW       = 16,
  parameter int unsigned CW       = 16,
  parameter int unsigned WIN_BASE = 64,
  parameter int unsigned WIN_SIZE = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [47:0]   mac_addr,
  input  logic          cfg_word16,
  input  logic [AW-1:0] ring_start,
  input  logic [AW-1:0] ring_stop,
  input  logic          ld_addr,
  input  logic [AW-1:0] ld_addr_val,
  input  logic          ld_cnt,
  input  logic [CW-1:0] ld_cnt_val,
  input  logic          cmd_wr,
  input  logic          cmd_stop,
  input  logic          cmd_rrd,
  input  logic          cmd_rwr,
  input  logic          port_rd,
  input  logic          port_wr,
  input  logic          port_sel,
  input  logic          port_dword,
  input  logic [31:0]   port_wdata,
  output logic [31:0]   port_rdata,
  output logic [AW-1:0] dma_addr,
  output logic [CW-1:0] dma_cnt,
  output logic          dma_done,
  output logic          reset_done,
  input  logic          rx_we,
  input  logic [AW-1:0] rx_addr,
  input  logic [7:0]    rx_data,
  output logic          rx_stall
);

  acc_width_e  acc_w;
  logic        rd_acc, wr_acc, data_acc, rst_rd, wr_ok;
  logic        init_q, prom_load, rdata_en, rst_done_q;
  logic [31:0] mem_rdata, rdata_nxt, rdata_q;

  assign rd_acc    = port_rd & ~port_sel;
  assign wr_acc    = port_wr & ~port_sel;
  assign data_acc  = rd_acc | wr_acc;
  assign rst_rd    = port_rd & port_sel;
  assign acc_w     = port_dword ? ACC_B32 : (cfg_word16 ? ACC_B16 : ACC_B8);
  assign prom_load = init_q | rst_rd;
  assign rx_stall  = rx_we & data_acc;
  assign rdata_en  = rd_acc | rst_rd;
  assign rdata_nxt = rst_rd ? 32'h0 : mem_rdata;

  rdma_addr_ctl #(.AW(AW), .CW(CW)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_start  (ring_start),
    .ring_stop   (ring_stop),
    .ld_addr     (ld_addr),
    .ld_addr_val (ld_addr_val),
    .ld_cnt      (ld_cnt),
    .ld_cnt_val  (ld_cnt_val),
    .cmd_wr      (cmd_wr),
    .cmd_stop    (cmd_stop),
    .cmd_rrd     (cmd_rrd),
    .cmd_rwr     (cmd_rwr),
    .rd_acc      (rd_acc),
    .wr_acc      (wr_acc),
    .step        (width_bytes(acc_w)),
    .addr_q      (dma_addr),
    .cnt_q       (dma_cnt),
    .wr_ok       (wr_ok),
    .done_q      (dma_done)
  );

  rdma_pkt_mem #(.AW(AW), .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)) u_mem (
    .clk       (clk),
    .prom_load (prom_load),
    .mac       (mac_addr),
    .acc_addr  (dma_addr),
    .acc_w     (acc_w),
    .we        (wr_ok),
    .wdata     (port_wdata),
    .rdata     (mem_rdata),
    .rx_we     (rx_we & ~data_acc),
    .rx_addr   (rx_addr),
    .rx_data   (rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q     <= 1'b1;
      rst_done_q <= 1'b0;
      rdata_q    <= '0;
    end else begin
      init_q     <= 1'b0;
      rst_done_q <= prom_load;
      if (rdata_en) rdata_q <= rdata_nxt;
    end
  end

  assign port_rdata = rdata_q;
  assign reset_done = rst_done_q;

  // R10
  rx_stall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stall |-> (rx_we && (port_rd || port_wr) && !port_sel));

endmodule

// File: tb/sim_rdma_port_engine.sv
`timescale 1ns/1ps
module sim_rdma_port_engine;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [47:0] mac_addr = 48'hC0FFEE123456;
  logic        cfg_word16;
  logic [15:0] ring_start, ring_stop, ld_addr_val, ld_cnt_val, rx_addr;
  logic        ld_addr, ld_cnt, cmd_wr, cmd_stop, cmd_rrd, cmd_rwr;
  logic        port_rd, port_wr, port_sel, port_dword, rx_we;
  logic [31:0] port_wdata, port_rdata;
  logic [15:0] dma_addr, dma_cnt;
  logic        dma_done, reset_done, rx_stall;
  logic [7:0]  rx_data;

  int total = 0;
  int fails = 0;
  bit finished = 0;
  logic [7:0] model [0:127];

  always #2.5 clk = ~clk;

  rdma_port_engine u0 (
    .clk(clk), .rst_n(rst_n), .mac_addr(mac_addr), .cfg_word16(cfg_word16),
    .ring_start(ring_start), .ring_stop(ring_stop),
    .ld_addr(ld_addr), .ld_addr_val(ld_addr_val), .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
    .cmd_wr(cmd_wr), .cmd_stop(cmd_stop), .cmd_rrd(cmd_rrd), .cmd_rwr(cmd_rwr),
    .port_rd(port_rd), .port_wr(port_wr), .port_sel(port_sel), .port_dword(port_dword),
    .port_wdata(port_wdata), .port_rdata(port_rdata),
    .dma_addr(dma_addr), .dma_cnt(dma_cnt), .dma_done(dma_done), .reset_done(reset_done),
    .rx_we(rx_we), .rx_addr(rx_addr), .rx_data(rx_data), .rx_stall(rx_stall)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic acc(input bit rd, input bit sel, input bit dw, input logic [31:0] wd);
    port_rd = rd; port_wr = !rd; port_sel = sel; port_dword = dw; port_wdata = wd;
    tick();
    port_rd = 0; port_wr = 0; port_sel = 0; port_dword = 0;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    ld_addr = 1; ld_cnt = 1; ld_addr_val = a; ld_cnt_val = c;
    tick();
    ld_addr = 0; ld_cnt = 0;
  endtask

  task automatic cmd(input bit stp, input bit rr, input bit rw);
    cmd_wr = 1; cmd_stop = stp; cmd_rrd = rr; cmd_rwr = rw;
    tick();
    cmd_wr = 0; cmd_stop = 0; cmd_rrd = 0; cmd_rwr = 0;
  endtask

  function automatic logic [7:0] prom_exp(input int j);
    int i;
    logic [47:0] sh;
    i = j / 2;
    sh = mac_addr >> (8 * (i % 8));
    if (i < 6) return sh[7:0];
    if (i == 14 || i == 15) return 8'h57;
    return 8'h00;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_word16 = 0; ring_start = 16'd64; ring_stop = 16'd128;
    ld_addr = 0; ld_cnt = 0; ld_addr_val = 0; ld_cnt_val = 0;
    cmd_wr = 0; cmd_stop = 0; cmd_rrd = 0; cmd_rwr = 0;
    port_rd = 0; port_wr = 0; port_sel = 0; port_dword = 0; port_wdata = 0;
    rx_we = 0; rx_addr = 0; rx_data = 0;
    repeat (3) @(negedge clk);
    chk("R3 reset addr", 32'(dma_addr), 32'd0);
    chk("R3 reset cnt", 32'(dma_cnt), 32'd0);
    chk("R3 reset done", 32'(dma_done), 32'd0);
    rst_n = 1;
    tick();
    chk("R9 reset_done after reset", 32'(reset_done), 32'd1);
    tick();
    chk("R9 reset_done single pulse", 32'(reset_done), 32'd0);
    for (int j = 0; j < 32; j++) model[j] = prom_exp(j);

    // R8: full PROM sweep with byte reads
    load(16'd0, 16'd32);
    for (int j = 0; j < 32; j++) begin
      acc(1, 0, 0, 0);
      chk("R8 prom byte", port_rdata, {24'h0, prom_exp(j)});
      if (j == 30) chk("R3 no early done", 32'(dma_done), 32'd0);
    end
    chk("R3 done at end", 32'(dma_done), 32'd1);
    chk("R3 count zero", 32'(dma_cnt), 32'd0);
    chk("R1 byte step", 32'(dma_addr), 32'd32);

    // R1/R2: 16-bit writes over the whole window, wrapping at the stop
    cfg_word16 = 1;
    load(16'd64, 16'd64);
    for (int i = 0; i < 32; i++) begin
      logic [15:0] w;
      w = 16'hA000 + 16'(i * 37);
      acc(0, 0, 0, {16'h0, w});
      model[64 + 2*i] = w[7:0];
      model[65 + 2*i] = w[15:8];
      if (i == 15) begin
        chk("R1 word step", 32'(dma_addr), 32'd96);
        chk("R3 count step 2", 32'(dma_cnt), 32'd32);
      end
    end
    chk("R2 wrap to start", 32'(dma_addr), 32'd64);
    chk("R3 done after words", 32'(dma_done), 32'd1);

    // R1: byte readback gives little-endian placement
    cfg_word16 = 0;
    load(16'd64, 16'd64);
    for (int j = 0; j < 64; j++) begin
      acc(1, 0, 0, 0);
      chk("R1 byte readback", port_rdata, {24'h0, model[64 + j]});
    end

    // R7: 32-bit accesses at odd addresses
    load(16'd67, 16'd8);
    acc(0, 0, 1, 32'h11223344);
    model[66] = 8'h44; model[67] = 8'h33; model[68] = 8'h22; model[69] = 8'h11;
    chk("R7 unmasked step", 32'(dma_addr), 32'd71);
    acc(0, 0, 1, 32'hA5B6C7D8);
    model[70] = 8'hD8; model[71] = 8'hC7; model[72] = 8'hB6; model[73] = 8'hA5;
    chk("R3 dword done", 32'(dma_done), 32'd1);
    chk("R1 dword step", 32'(dma_addr), 32'd75);
    load(16'd66, 16'd4);
    acc(1, 0, 1, 0);
    chk("R1 dword read", port_rdata, 32'h11223344);
    load(16'd71, 16'd4);
    acc(1, 0, 1, 0);
    chk("R7 odd dword read", port_rdata, 32'hA5B6C7D8);
    cfg_word16 = 1;
    load(16'd69, 16'd2);
    acc(1, 0, 0, 0);
    chk("R7 odd word read", port_rdata, 32'h00001122);

    // R2: wrap at a short ring
    ring_stop = 16'd80;
    load(16'd76, 16'd10);
    acc(1, 0, 0, 0);
    chk("R2 step before stop", 32'(dma_addr), 32'd78);
    acc(1, 0, 0, 0);
    chk("R2 reload start", 32'(dma_addr), 32'd64);
    chk("R3 count 6", 32'(dma_cnt), 32'd6);
    chk("R1 word read", port_rdata, {16'h0, model[79], model[78]});
    ring_stop = 16'd128;

    // R3/R4: count below step, then read at zero
    load(16'd64, 16'd3);
    acc(1, 0, 0, 0);
    chk("R3 cnt 3->1", 32'(dma_cnt), 32'd1);
    chk("R3 no done", 32'(dma_done), 32'd0);
    acc(1, 0, 0, 0);
    chk("R3 cnt 1->0", 32'(dma_cnt), 32'd0);
    chk("R3 done short", 32'(dma_done), 32'd1);
    acc(1, 0, 0, 0);
    chk("R4 read at zero steps", 32'(dma_addr), 32'd70);
    chk("R4 read at zero done", 32'(dma_done), 32'd1);

    // R4: write at zero count ignored
    cfg_word16 = 0;
    load(16'd90, 16'd0);
    acc(0, 0, 0, 32'h77);
    chk("R4 write ignored addr", 32'(dma_addr), 32'd90);
    chk("R4 write ignored done", 32'(dma_done), 32'd0);
    load(16'd90, 16'd1);
    acc(1, 0, 0, 0);
    chk("R4 memory unchanged", port_rdata, {24'h0, model[90]});

    // R6: outside the window
    load(16'd40, 16'd8);
    acc(1, 0, 0, 0);
    chk("R6 byte gap read", port_rdata, 32'h000000FF);
    chk("R6 addr still steps", 32'(dma_addr), 32'd41);
    cfg_word16 = 1;
    acc(1, 0, 0, 0);
    chk("R6 word gap read", port_rdata, 32'h0000FFFF);
    load(16'd126, 16'd4);
    acc(0, 0, 1, 32'hDEADBEEF);
    cfg_word16 = 0;
    load(16'd126, 16'd2);
    acc(1, 0, 0, 0);
    chk("R6 straddle write dropped", port_rdata, {24'h0, model[126]});
    acc(1, 0, 0, 0);
    chk("R6 straddle write dropped", port_rdata, {24'h0, model[127]});
    load(16'd126, 16'd4);
    acc(1, 0, 1, 0);
    chk("R6 straddle dword read", port_rdata, 32'hFFFFFFFF);
    load(16'd30, 16'd4);
    acc(1, 0, 1, 0);
    chk("R6 prom edge dword read", port_rdata, 32'hFFFFFFFF);
    load(16'd28, 16'd4);
    acc(1, 0, 1, 0);
    chk("R6 prom dword read", port_rdata,
        {prom_exp(31), prom_exp(30), prom_exp(29), prom_exp(28)});

    // R5: zero-length commands
    load(16'd64, 16'd0);
    cmd(0, 1, 0);
    chk("R5 remote read zero", 32'(dma_done), 32'd1);
    cmd(0, 0, 1);
    chk("R5 remote write zero", 32'(dma_done), 32'd1);
    cmd(1, 1, 0);
    chk("R5 stop blocks", 32'(dma_done), 32'd0);
    cmd(0, 0, 0);
    chk("R5 no remote bit", 32'(dma_done), 32'd0);
    load(16'd64, 16'd5);
    cmd(0, 1, 0);
    chk("R5 nonzero count", 32'(dma_done), 32'd0);

    // R9: reset port
    load(16'd0, 16'd1);
    acc(0, 0, 0, 32'h00);
    load(16'd0, 16'd1);
    acc(1, 0, 0, 0);
    chk("R9 prom overwritten", port_rdata, 32'h0);
    acc(0, 1, 0, 32'hFF);
    chk("R9 reset write no pulse", 32'(reset_done), 32'd0);
    chk("R9 reset write no step", 32'(dma_addr), 32'd1);
    load(16'd2, 16'd1);
    acc(1, 0, 0, 0);
    chk("R8 mac byte 1", port_rdata, {24'h0, prom_exp(2)});
    acc(1, 1, 0, 0);
    chk("R9 reset read zero", port_rdata, 32'h0);
    chk("R9 reset pulse", 32'(reset_done), 32'd1);
    load(16'd0, 16'd1);
    acc(1, 0, 0, 0);
    chk("R9 prom reloaded", port_rdata, {24'h0, prom_exp(0)});

    // R10: receive writer
    rx_we = 1; rx_addr = 16'd100; rx_data = 8'h5C;
    #1 chk("R10 no stall alone", 32'(rx_stall), 32'd0);
    tick();
    rx_we = 0;
    model[100] = 8'h5C;
    load(16'd64, 16'd4);
    rx_we = 1; rx_addr = 16'd101; rx_data = 8'h6D; port_rd = 1;
    #1 chk("R10 stall on clash", 32'(rx_stall), 32'd1);
    tick();
    rx_we = 0; port_rd = 0;
    load(16'd100, 16'd2);
    acc(1, 0, 0, 0);
    chk("R10 byte stored", port_rdata, {24'h0, model[100]});
    acc(1, 0, 0, 0);
    chk("R10 stalled byte dropped", port_rdata, {24'h0, model[101]});

    // R11: load wins over an access in the same cycle
    load(16'd64, 16'd4);
    ld_addr = 1; ld_cnt = 1; ld_addr_val = 16'd100; ld_cnt_val = 16'd9; port_rd = 1;
    tick();
    ld_addr = 0; ld_cnt = 0; port_rd = 0;
    chk("R11 load priority addr", 32'(dma_addr), 32'd100);
    chk("R11 load priority cnt", 32'(dma_cnt), 32'd9);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule